// File: doc/BRIEF.md
# Sync Clock Frequency Classifier

This block watches an asynchronous synchronization clock, times each of its periods with a fast reference clock and sorts the result into one of five frequency bands. Each band has a 3-bit code that names the internal oscillator frequency used for that band. The block also reports when the external clock is steady, and whether the converter is currently following it.

A one-time start pulse sets the fallback policy. Suppose the external clock is already steady when start arrives. The block then stores the band of the first good period seen after start, and that code becomes the frequency used whenever the clock later disappears. Suppose instead that no clock is present at start. The fallback then comes from a configuration select input, and no band is ever stored. While the clock is present, the output code always tracks the band that was measured most recently.

Top module: `sync_freq_classifier`

## Requirements
- R1: Codes are 3-bit indices in ascending frequency order. At the default 200 MHz reference, a rising-edge interval of 334..500 cycles gives 0, 234..333 cycles gives 1, 167..233 gives 2, 111..166 gives 3 and 76..110 gives 4. These correspond to 500, 750, 1000, 1500 and 2200 kHz internal frequency.
- R2: Each band includes its lower frequency edge. An interval equal to floor(reference kHz / band lower kHz) cycles belongs to that band, so 333 cycles maps to code 1 and 334 cycles maps to code 0.
- R3: sync_present rises after 4 consecutive intervals inside the 76..500 cycle window. While sync_present is high, freq_code equals the band of the latest interval.
- R4: An interval shorter than 76 or longer than 500 cycles clears sync_present on the next cycle and never alters the stored fallback code.
- R5: If no rising edge arrives within 625 cycles of the previous one, sync_present drops. A gap of 450 cycles keeps it high.
- R6: While sync_present is low, freq_code is the stored code if one exists. Otherwise it is fallback_sel, and any value above 4 is clamped to 4.
- R7: locked is high only while sync_present is high and a start pulse has been received since reset.
- R8: If start arrives while sync_present is high, the band of the first in-window interval after start is stored. Later frequency changes, later start pulses and fallback_sel changes leave the stored code unchanged until reset.
- R9: If start arrives while sync_present is low, nothing is stored. After a clock later appears and is lost again, freq_code returns to fallback_sel.
- R10: Reset is synchronous and active high. After reset, sync_present and locked are low and freq_code shows fallback_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 200 MHz by default |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous external synchronization clock |
| start | input | 1 | Start-up pulse; only the first one after reset has effect |
| fallback_sel | input | 3 | Configured internal frequency code |
| freq_code | output | 3 | Selected internal frequency code, 0..4 |
| sync_present | output | 1 | External clock is steady and in range |
| locked | output | 1 | Switching follows the external clock |

## Verification
A run counter that is off by one makes sync_present rise one period early or one period late. This shows at the ports within a few hundred reference cycles of the first edge. A wrong stored code stays hidden while the clock runs, and only appears as a wrong freq_code once the clock stops. The bench therefore removes the clock after each start scenario and waits out the 625-cycle loss window before it compares. Band boundary errors show directly in the code one interval after a boundary period, so both sides of every boundary are driven.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int NUM_BANDS = 5;
    localparam int CODE_W    = 3;
    localparam int MAX_KHZ   = 2640;
    localparam int BAND_LO_KHZ [NUM_BANDS] = '{400, 600, 857, 1200, 1810};

    typedef logic [CODE_W-1:0] code_t;

    // Longest interval (reference cycles) that still belongs to band k.
    function automatic int band_max_cyc(int ref_khz, int k);
        return ref_khz / BAND_LO_KHZ[k];
    endfunction

    // Shortest interval that belongs to band k.
    function automatic int band_min_cyc(int ref_khz, int k);
        if (k == NUM_BANDS - 1)
            return (ref_khz + MAX_KHZ - 1) / MAX_KHZ;
        return ref_khz / BAND_LO_KHZ[k+1] + 1;
    endfunction
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;
endmodule

// File: rtl/sfc_period.sv
module sfc_period #(
    parameter int CNT_W    = 10,
    parameter int LOSS_CYC = 625
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    output logic [CNT_W-1:0] period,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] LOSS_C = CNT_W'(LOSS_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (rise)
            cnt_d = CNT_W'(1);
        else if (cnt_q < LOSS_C)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LOSS_C;
        else     cnt_q <= cnt_d;
    end

    assign period  = cnt_q;
    assign timeout = !rise && (cnt_q == LOSS_C);
endmodule

// File: rtl/sfc_band.sv
module sfc_band
    import sfc_pkg::*;
#(
    parameter int REF_KHZ = 200000,
    parameter int CNT_W   = 10
) (
    input  logic [CNT_W-1:0] period,
    output logic             in_win,
    output code_t            code
);
    logic [NUM_BANDS-1:0] hit;

    genvar k;
    for (k = 0; k < NUM_BANDS; k++) begin : g_band
        localparam logic [CNT_W-1:0] HI_C = CNT_W'(band_max_cyc(REF_KHZ, k));
        localparam logic [CNT_W-1:0] LO_C = CNT_W'(band_min_cyc(REF_KHZ, k));
        assign hit[k] = (period >= LO_C) && (period <= HI_C);
    end

    always_comb begin
        code = '0;
        for (int b = 0; b < NUM_BANDS; b++)
            if (hit[b]) code = code_t'(b);
    end

    assign in_win = |hit;
endmodule

// File: rtl/sync_freq_classifier.sv
module sync_freq_classifier
    import sfc_pkg::*;
#(
    parameter int REF_KHZ  = 200000,
    parameter int GOOD_RUN = 4,
    parameter int LOSS_PCT = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic              start,
    input  logic [CODE_W-1:0] fallback_sel,
    output logic [CODE_W-1:0] freq_code,
    output logic              sync_present,
    output logic              locked
);
    localparam int SLOW_CYC = band_max_cyc(REF_KHZ, 0);
    localparam int LOSS_CYC = SLOW_CYC * LOSS_PCT / 100;
    localparam int CNT_W    = $clog2(LOSS_CYC + 1);
    localparam int RUN_W    = $clog2(GOOD_RUN + 1);
    localparam code_t TOP_CODE = code_t'(NUM_BANDS - 1);

    typedef struct packed {
        logic             started;
        logic             ext_at_start;
        logic             latched_ok;
        code_t            latched;
        code_t            band;
        logic [RUN_W-1:0] run;
        logic             present;
        code_t            out_code;
        logic             locked;
    } st_t;

    st_t st_d, st_q;

    logic             rise;
    logic [CNT_W-1:0] period;
    logic             timeout;
    logic             in_win;
    code_t            band_code;
    logic             meas_valid;
    logic             meas_bad;
    code_t            sel_c;

    sfc_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .rise     (rise)
    );

    sfc_period #(.CNT_W(CNT_W), .LOSS_CYC(LOSS_CYC)) u_period (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .period  (period),
        .timeout (timeout)
    );

    sfc_band #(.REF_KHZ(REF_KHZ), .CNT_W(CNT_W)) u_band (
        .period (period),
        .in_win (in_win),
        .code   (band_code)
    );

    assign meas_valid = rise && in_win;
    assign meas_bad   = (rise && !in_win) || timeout;
    assign sel_c      = (fallback_sel > TOP_CODE) ? TOP_CODE : fallback_sel;

    always_comb begin
        st_d = st_q;

        // presence tracking
        if (meas_bad)
            st_d.run = '0;
        else if (meas_valid && st_q.run < RUN_W'(GOOD_RUN))
            st_d.run = st_q.run + 1'b1;
        st_d.present = !meas_bad &&
                       (st_q.present || (meas_valid && st_q.run >= RUN_W'(GOOD_RUN - 1)));
        if (meas_valid)
            st_d.band = band_code;

        // one-time start handling
        if (start && !st_q.started) begin
            st_d.started      = 1'b1;
            st_d.ext_at_start = st_q.present;
        end
        if (st_q.started && st_q.ext_at_start && !st_q.latched_ok && meas_valid) begin
            st_d.latched_ok = 1'b1;
            st_d.latched    = band_code;
        end

        // output selection
        if (st_d.present)
            st_d.out_code = st_d.band;
        else if (st_d.latched_ok)
            st_d.out_code = st_d.latched;
        else
            st_d.out_code = sel_c;
        st_d.locked = st_d.present && st_d.started;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign freq_code    = st_q.out_code;
    assign sync_present = st_q.present;
    assign locked       = st_q.locked;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker
    import sfc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input code_t freq_code,
    input logic  sync_present,
    input logic  meas_valid,
    input logic  meas_bad,
    input logic  timeout,
    input logic  latched_ok,
    input code_t latched
);
    assert_code_range_R1: assert property (@(posedge clk) disable iff (rst)
        freq_code <= code_t'(NUM_BANDS - 1));

    assert_rise_after_valid_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_present) |-> $past(meas_valid));

    assert_bad_period_drops_R4: assert property (@(posedge clk) disable iff (rst)
        meas_bad |=> !sync_present);

    assert_loss_drops_R5: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !sync_present);

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        latched_ok |=> (latched_ok && $stable(latched)));
endmodule

bind sync_freq_classifier sfc_checker u_sfc_checker (
    .clk          (clk),
    .rst          (rst),
    .freq_code    (freq_code),
    .sync_present (sync_present),
    .meas_valid   (meas_valid),
    .meas_bad     (meas_bad),
    .timeout      (timeout),
    .latched_ok   (st_q.latched_ok),
    .latched      (st_q.latched)
);

// File: tb/sync_freq_classifier_bench.sv
module sync_freq_classifier_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic       start = 1'b0;
    logic [2:0] fallback_sel = 3'd1;
    logic [2:0] freq_code;
    logic       sync_present;
    logic       locked;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sync_freq_classifier u_sync_freq_classifier (
        .clk          (clk),
        .rst          (rst),
        .sync_in      (sync_in),
        .start        (start),
        .fallback_sel (fallback_sel),
        .freq_code    (freq_code),
        .sync_present (sync_present),
        .locked       (locked)
    );

    // interval (cycles), expected code, expected presence; fallback_sel = 1
    localparam int NV = 14;
    localparam int VP [NV] = '{500, 334, 333, 234, 233, 167, 166, 111, 110, 76, 75, 501, 120, 200};
    localparam int VC [NV] = '{  0,   0,   1,   1,   2,   2,   3,   3,   4,  4,  1,   1,   3,   2};
    localparam int VS [NV] = '{  1,   1,   1,   1,   1,   1,   1,   1,   1,  1,  0,   0,   1,   1};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic gen(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            sync_in = 1'b1;
            repeat (per / 2) @(negedge clk);
            sync_in = 1'b0;
            repeat (per - per / 2) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(5);
        rst = 1'b0;
        idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R10 reset state
        fallback_sel = 3'd3;
        do_reset();
        chk("R10 present", sync_present, 0);
        chk("R10 locked", locked, 0);
        chk("R10 code", freq_code, 3);
        // R6 clamp
        fallback_sel = 3'd6;
        idle(2);
        chk("R6 clamp", freq_code, 4);

        // band table, no start (R1 R2 R3 R4)
        fallback_sel = 3'd1;
        for (int i = 0; i < NV; i++) begin
            gen(VP[i], 8);
            chk($sformatf("R1 R2 code p=%0d", VP[i]), freq_code, VC[i]);
            chk($sformatf("R3 R4 present p=%0d", VP[i]), sync_present, VS[i]);
            chk($sformatf("R7 locked p=%0d", VP[i]), locked, 0);
        end

        // R5 loss margin
        gen(150, 8);
        idle(300);
        chk("R5 gap 450 present", sync_present, 1);
        idle(300);
        chk("R5 gap 750 present", sync_present, 0);
        chk("R6 fallback sel", freq_code, 1);

        // R9 start while absent
        pulse_start();
        gen(150, 8);
        chk("R7 locked after start", locked, 1);
        chk("R3 code follow", freq_code, 3);
        idle(700);
        chk("R9 no latch", freq_code, 1);
        chk("R7 locked drop", locked, 0);

        // R8 start while present
        fallback_sel = 3'd0;
        do_reset();
        gen(100, 8);
        chk("R7 present before start", locked, 0);
        pulse_start();
        gen(100, 4);
        chk("R8 locked", locked, 1);
        chk("R8 code", freq_code, 4);
        gen(400, 8);
        chk("R3 follow new band", freq_code, 0);
        pulse_start();
        idle(700);
        chk("R8 latched fallback", freq_code, 4);
        chk("R5 lost", sync_present, 0);
        fallback_sel = 3'd2;
        idle(3);
        chk("R8 sel ignored", freq_code, 4);
        gen(75, 8);
        chk("R4 bad period present", sync_present, 0);
        chk("R4 latch untouched", freq_code, 4);
        gen(300, 8);
        chk("R3 follow 300", freq_code, 1);
        idle(700);
        chk("R8 latch held", freq_code, 4);

        finish_run();
    end
endmodule